// File: doc/BRIEF.md
# Register File with Side-Channel Upset Port

This block is a processor register file with a second, independent write port through which a fault injector can overwrite one register with a precomputed faulty value. The core keeps running the whole time. The faulty value arrives fully formed from outside; the block never reads a register back to work out what to write.

A single-cycle trigger names the target index and the value. A collision manager then commits that value in the first cycle in which the processor is not writing the same register. The injection may commit in the trigger cycle itself. If the processor is writing the target in that cycle, the processor write takes effect and the injection stays pending. Any read port that addresses the target in the commit cycle returns the injected value in that same cycle.

The block can give up on a pending injection after a programmable number of blocked cycles and raise a flag, so that the experiment can be discarded. Register 0 can be built as a read-only register.

Top module: `inj_regfile`

## Requirements
- R1: After synchronous reset, every register reads 0, and inj_busy, inj_err and inj_abort are 0.
- R2: Reads are combinational from the array. A processor write (pw_en) becomes visible on the read ports from the cycle after it is presented, and a same-cycle read still returns the old value.
- R3: A trigger (inj_trig high for one cycle, while inj_busy is 0) that meets no processor write to its target commits in that same cycle: inj_done is 1 in that cycle, the register holds inj_val from the next cycle, and inj_busy stays 0.
- R4: When the processor writes the target register in the trigger cycle, or in any pending cycle, the processor write takes effect and inj_done stays 0. inj_busy is then 1 from the next cycle. The injection commits, with inj_done at 1, in the first cycle without such a write, and it overwrites the value the processor wrote.
- R5: In the commit cycle, any read port whose index equals the target returns the injected value. Read ports on other indexes return the array contents.
- R6: A processor write to a different register in the commit cycle lands together with the injection.
- R7: A trigger that arrives while inj_busy is 1 is ignored. Its target register keeps its value.
- R8: With tmo_en at 1 and a limit L ≥ 1, an injection that stays blocked for L consecutive cycles, counting the trigger cycle, is abandoned at the end of the L-th blocked cycle. From the next cycle inj_busy is 0 and inj_abort is 1, no commit happens, and the register keeps the processor's value. inj_abort stays at 1 until the next trigger that is accepted.
- R9: With tmo_en at 0, a blocked injection stays pending without limit.
- R10: With the read-only option set (the default), a trigger that targets index 0 is rejected: inj_err is 1 from the next cycle, inj_busy stays 0, inj_done stays 0, and register 0 stays 0. Processor writes to index 0 are also ignored. The next accepted trigger clears inj_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_en | input | 1 | Processor write enable |
| pw_idx | input | AW | Processor write register index |
| pw_data | input | DW | Processor write data |
| rd_idx | input | NRD*AW | Read indexes, port k in bits [k*AW +: AW] |
| rd_data | output | NRD*DW | Read data, port k in bits [k*DW +: DW] |
| inj_trig | input | 1 | Injection request strobe |
| inj_idx | input | AW | Injection target register |
| inj_val | input | DW | Predetermined faulty value |
| tmo_en | input | 1 | Enables abandoning a blocked injection |
| tmo_limit | input | TW | Number of blocked cycles allowed |
| inj_done | output | 1 | High in the cycle the injection commits |
| inj_busy | output | 1 | Injection pending after a collision |
| inj_err | output | 1 | Last accepted trigger targeted read-only register 0 |
| inj_abort | output | 1 | Last accepted injection was abandoned on timeout |

## Verification
The hardest case to reach from the ports is an injection that stays pending over several cycles, with the processor writing the target in each of them, and that then commits in a cycle where the processor writes a different register and a read port sits on the target. The bench holds pw_idx on the target for a chosen run of cycles after the trigger and then moves it to another register. It checks the forwarded read and both writes. The same held-collision stimulus, run against a short timeout limit, drives the abandon path. Run with the timeout disabled, it shows that the injection stays pending.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    typedef enum logic {
        INJ_IDLE = 1'b0,
        INJ_PEND = 1'b1
    } inj_state_e;

    typedef struct packed {
        logic accept;
        logic reject;
        logic active;
        logic commit;
        logic blocked;
        logic abandon;
    } inj_flags_t;

    function automatic logic idx_hit(input logic en, input int unsigned a, input int unsigned b);
        return en && (a == b);
    endfunction

endpackage

// File: rtl/rfi_store.sv
module rfi_store #(
    parameter int N   = 16,
    parameter int DW  = 32,
    parameter int AW  = 4,
    parameter bit RO0 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pw_en,
    input  logic [AW-1:0]        pw_idx,
    input  logic [DW-1:0]        pw_data,
    input  logic                 iw_en,
    input  logic [AW-1:0]        iw_idx,
    input  logic [DW-1:0]        iw_data,
    output logic [N-1:0][DW-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        if (RO0 && g == 0) begin : g_fixed
            assign q[g] = '0;
        end else begin : g_live
            logic [DW-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= '0;
                else if (rfi_pkg::idx_hit(iw_en, int'(iw_idx), g))
                    r <= iw_data;
                else if (rfi_pkg::idx_hit(pw_en, int'(pw_idx), g))
                    r <= pw_data;
            end
            assign q[g] = r;
        end
    end
endmodule

// File: rtl/rfi_rdport.sv
module rfi_rdport #(
    parameter int N   = 16,
    parameter int DW  = 32,
    parameter int AW  = 4,
    parameter int NRD = 2
) (
    input  logic [N-1:0][DW-1:0] q,
    input  logic [NRD*AW-1:0]    rd_idx,
    input  logic                 byp_en,
    input  logic [AW-1:0]        byp_idx,
    input  logic [DW-1:0]        byp_data,
    output logic [NRD*DW-1:0]    rd_data
);
    for (genvar p = 0; p < NRD; p++) begin : g_port
        logic [AW-1:0] sel;
        assign sel = rd_idx[p*AW +: AW];
        always_comb begin
            if (byp_en && sel == byp_idx)
                rd_data[p*DW +: DW] = byp_data;
            else
                rd_data[p*DW +: DW] = q[sel];
        end
    end
endmodule

// File: rtl/rfi_collide.sv
module rfi_collide
    import rfi_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 32,
    parameter int TW  = 8,
    parameter bit RO0 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [AW-1:0] trig_idx,
    input  logic [DW-1:0] trig_val,
    input  logic          tmo_en,
    input  logic [TW-1:0] tmo_limit,
    input  logic          pw_en,
    input  logic [AW-1:0] pw_idx,
    output logic [AW-1:0] cur_idx,
    output logic [DW-1:0] cur_val,
    output logic          commit,
    output logic          busy,
    output logic          err,
    output logic          abort
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    inj_state_e    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [DW-1:0] val_q;
    logic [TW-1:0] cnt_q, cnt_n;
    logic          err_q, abort_q;
    inj_flags_t    f;

    always_comb begin
        f        = '0;
        f.accept = trig && (state_q == INJ_IDLE);
        f.reject = f.accept && RO0 && (trig_idx == '0);
        f.active = (state_q == INJ_PEND) || (f.accept && !f.reject);
        cur_idx  = (state_q == INJ_PEND) ? idx_q : trig_idx;
        cur_val  = (state_q == INJ_PEND) ? val_q : trig_val;
        f.blocked = f.active && pw_en && (pw_idx == cur_idx);
        f.commit  = f.active && !f.blocked;
        if (state_q == INJ_IDLE)
            cnt_n = TW'(1);
        else if (cnt_q == CNT_MAX)
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + TW'(1);
        f.abandon = f.blocked && tmo_en && (cnt_n >= tmo_limit);
        state_d   = (f.blocked && !f.abandon) ? INJ_PEND : INJ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INJ_IDLE;
            idx_q   <= '0;
            val_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= cur_idx;
            val_q   <= cur_val;
            cnt_q   <= f.blocked ? cnt_n : '0;
            if (f.accept)
                err_q <= f.reject;
            abort_q <= (f.accept ? 1'b0 : abort_q) | f.abandon;
        end
    end

    assign commit = f.commit;
    assign busy   = (state_q == INJ_PEND);
    assign err    = err_q;
    assign abort  = abort_q;
endmodule

// File: rtl/inj_regfile.sv
module inj_regfile #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    parameter int TW    = 8,
    parameter bit RO0   = 1'b1,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pw_en,
    input  logic [AW-1:0]     pw_idx,
    input  logic [DW-1:0]     pw_data,
    input  logic [NRD*AW-1:0] rd_idx,
    output logic [NRD*DW-1:0] rd_data,
    input  logic              inj_trig,
    input  logic [AW-1:0]     inj_idx,
    input  logic [DW-1:0]     inj_val,
    input  logic              tmo_en,
    input  logic [TW-1:0]     tmo_limit,
    output logic              inj_done,
    output logic              inj_busy,
    output logic              inj_err,
    output logic              inj_abort
);
    logic [NREGS-1:0][DW-1:0] q;
    logic [AW-1:0]            tgt_idx;
    logic [DW-1:0]            tgt_val;
    logic                     commit;

    rfi_collide #(.AW(AW), .DW(DW), .TW(TW), .RO0(RO0)) u_collide (
        .clk(clk), .rst(rst),
        .trig(inj_trig), .trig_idx(inj_idx), .trig_val(inj_val),
        .tmo_en(tmo_en), .tmo_limit(tmo_limit),
        .pw_en(pw_en), .pw_idx(pw_idx),
        .cur_idx(tgt_idx), .cur_val(tgt_val),
        .commit(commit), .busy(inj_busy), .err(inj_err), .abort(inj_abort)
    );

    rfi_store #(.N(NREGS), .DW(DW), .AW(AW), .RO0(RO0)) u_store (
        .clk(clk), .rst(rst),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .iw_en(commit), .iw_idx(tgt_idx), .iw_data(tgt_val),
        .q(q)
    );

    rfi_rdport #(.N(NREGS), .DW(DW), .AW(AW), .NRD(NRD)) u_rd (
        .q(q), .rd_idx(rd_idx),
        .byp_en(commit), .byp_idx(tgt_idx), .byp_data(tgt_val),
        .rd_data(rd_data)
    );

    assign inj_done = commit;
endmodule

// File: rtl/rfi_checker.sv
module rfi_checker #(
    parameter int AW  = 4,
    parameter int DW  = 32,
    parameter int NRD = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pw_en,
    input logic [AW-1:0]     pw_idx,
    input logic [NRD*AW-1:0] rd_idx,
    input logic [NRD*DW-1:0] rd_data,
    input logic              inj_trig,
    input logic              tmo_en,
    input logic              inj_done,
    input logic              inj_busy,
    input logic              inj_err,
    input logic              inj_abort,
    input logic [AW-1:0]     tgt_idx,
    input logic [DW-1:0]     tgt_val
);
    // R3: a commit needs a live request
    p_done_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        inj_done |-> (inj_busy || inj_trig));

    // R3: commit ends the pending state
    p_done_clears_busy_r3: assert property (@(posedge clk) disable iff (rst)
        inj_done |=> !inj_busy);

    // R4: never commit over a processor write to the same register
    p_no_collision_r4: assert property (@(posedge clk) disable iff (rst)
        inj_done |-> !(pw_en && pw_idx == tgt_idx));

    // R5: read port 0 sees the injected value in the commit cycle
    p_forward_r5: assert property (@(posedge clk) disable iff (rst)
        (inj_done && rd_idx[AW-1:0] == tgt_idx) |-> rd_data[DW-1:0] == tgt_val);

    // R7: target is frozen while pending
    p_target_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (inj_busy && $past(inj_busy)) |-> $stable(tgt_idx));

    // R8: an abort only appears when a request ends without commit
    p_abort_drops_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(inj_abort) |-> (!inj_busy && $past(inj_busy || inj_trig) && !$past(inj_done)));

    // R9: with the timeout off, a blocked request stays pending
    p_no_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        (!tmo_en && inj_busy && !inj_done) |=> inj_busy);

    // R10: a rejected trigger never leaves a pending request
    p_reject_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(inj_err) |-> !inj_busy);
endmodule

bind inj_regfile rfi_checker #(.AW(AW), .DW(DW), .NRD(NRD)) u_chk (
    .clk(clk), .rst(rst), .pw_en(pw_en), .pw_idx(pw_idx),
    .rd_idx(rd_idx), .rd_data(rd_data), .inj_trig(inj_trig), .tmo_en(tmo_en),
    .inj_done(inj_done), .inj_busy(inj_busy), .inj_err(inj_err), .inj_abort(inj_abort),
    .tgt_idx(tgt_idx), .tgt_val(tgt_val)
);

// File: tb/sim_inj_regfile.sv
`timescale 1ns/1ps
module sim_inj_regfile;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pw_en = 1'b0;
    logic [AW-1:0] pw_idx = '0;
    logic [DW-1:0] pw_data = '0;
    logic [2*AW-1:0] rd_idx = '0;
    logic [2*DW-1:0] rd_data;
    logic          inj_trig = 1'b0;
    logic [AW-1:0] inj_idx = '0;
    logic [DW-1:0] inj_val = '0;
    logic          tmo_en = 1'b0;
    logic [7:0]    tmo_limit = '0;
    logic          inj_done, inj_busy, inj_err, inj_abort;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    inj_regfile u0 (
        .clk(clk), .rst(rst), .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .inj_trig(inj_trig), .inj_idx(inj_idx),
        .inj_val(inj_val), .tmo_en(tmo_en), .tmo_limit(tmo_limit),
        .inj_done(inj_done), .inj_busy(inj_busy), .inj_err(inj_err), .inj_abort(inj_abort)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance to 1 ns after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // settle combinational outputs before sampling
    task automatic settle();
        #1;
    endtask

    task automatic quiet();
        pw_en = 1'b0; inj_trig = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [AW-1:0] b);
        rd_idx = {b, a};
    endtask

    function automatic logic [DW-1:0] ra();
        return rd_data[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] rb();
        return rd_data[2*DW-1:DW];
    endfunction

    task automatic t_reset();
        step(); rd(4'd0, 4'd3); settle();
        chk("R1 reg0", ra(), 0);
        chk("R1 reg3", rb(), 0);
        chk("R1 busy", inj_busy, 0);
        chk("R1 err", inj_err, 0);
        chk("R1 abort", inj_abort, 0);
    endtask

    task automatic t_write();
        step(); pw_en = 1; pw_idx = 3; pw_data = 32'h1111_0003; rd(4'd3, 4'd3); settle();
        chk("R2 same-cycle old value", ra(), 0);
        step(); quiet(); settle();
        chk("R2 written value", ra(), 32'h1111_0003);
    endtask

    task automatic t_free_inject();
        step(); inj_trig = 1; inj_idx = 7; inj_val = 32'hDEAD_0007; rd(4'd7, 4'd3); settle();
        chk("R3 done in trigger cycle", inj_done, 1);
        chk("R5 forward on target", ra(), 32'hDEAD_0007);
        chk("R5 other port unaffected", rb(), 32'h1111_0003);
        step(); quiet(); settle();
        chk("R3 busy low", inj_busy, 0);
        chk("R3 value stored", ra(), 32'hDEAD_0007);
        chk("R3 done low after", inj_done, 0);
    endtask

    task automatic t_collision();
        step(); pw_en = 1; pw_idx = 5; pw_data = 32'h55; settle();
        step(); inj_trig = 1; inj_idx = 5; inj_val = 32'hBAD5;
        pw_data = 32'h5555_0001; rd(4'd5, 4'd9); settle();
        chk("R4 no done on collision", inj_done, 0);
        chk("R4 old value during collision", ra(), 32'h55);
        step(); inj_trig = 0; pw_data = 32'h5555_0002; settle();
        chk("R4 busy pending", inj_busy, 1);
        chk("R4 still blocked", inj_done, 0);
        chk("R4 processor write landed", ra(), 32'h5555_0001);
        step(); pw_idx = 9; pw_data = 32'h99; settle();
        chk("R4 commit when free", inj_done, 1);
        chk("R5 forward after wait", ra(), 32'hBAD5);
        step(); quiet(); settle();
        chk("R4 injection overwrote processor", ra(), 32'hBAD5);
        chk("R6 other write landed", rb(), 32'h99);
        chk("R4 busy cleared", inj_busy, 0);
    endtask

    task automatic t_busy_ignore();
        step(); inj_trig = 1; inj_idx = 2; inj_val = 32'hAAAA_0002;
        pw_en = 1; pw_idx = 2; pw_data = 32'h22; rd(4'd2, 4'd4); settle();
        step(); inj_idx = 4; inj_val = 32'hBBBB_0004; settle();
        chk("R7 busy while second trigger", inj_busy, 1);
        chk("R7 no done", inj_done, 0);
        step(); quiet(); settle();
        chk("R7 first injection commits", inj_done, 1);
        chk("R7 first value forwarded", ra(), 32'hAAAA_0002);
        step(); settle();
        chk("R7 ignored target unchanged", rb(), 0);
        chk("R7 busy cleared", inj_busy, 0);
    endtask

    task automatic t_timeout();
        tmo_en = 1; tmo_limit = 8'd3;
        step(); inj_trig = 1; inj_idx = 6; inj_val = 32'hFACE_0006;
        pw_en = 1; pw_idx = 6; pw_data = 32'h61; rd(4'd6, 4'd8); settle();
        step(); inj_trig = 0; pw_data = 32'h62; settle();
        chk("R8 pending after one block", inj_busy, 1);
        step(); pw_data = 32'h63; settle();
        chk("R8 still pending before limit", inj_busy, 1);
        step(); quiet(); settle();
        chk("R8 abandoned busy low", inj_busy, 0);
        chk("R8 abort set", inj_abort, 1);
        chk("R8 no commit", inj_done, 0);
        chk("R8 processor value kept", ra(), 32'h63);
        step(); settle();
        chk("R8 abort holds", inj_abort, 1);
        step(); inj_trig = 1; inj_idx = 8; inj_val = 32'h8888; settle();
        chk("R8 new trigger commits", inj_done, 1);
        step(); quiet(); settle();
        chk("R8 abort cleared by accepted trigger", inj_abort, 0);
        tmo_en = 0;
    endtask

    task automatic t_no_timeout();
        tmo_en = 0; tmo_limit = 8'd1;
        step(); inj_trig = 1; inj_idx = 10; inj_val = 32'h1010_1010;
        pw_en = 1; pw_idx = 10; pw_data = 32'hA0; rd(4'd10, 4'd0); settle();
        step(); inj_trig = 0;
        for (int i = 0; i < 6; i++) begin
            settle();
            chk("R9 pending without limit", inj_busy, 1);
            step();
        end
        quiet(); settle();
        chk("R9 commits after long wait", inj_done, 1);
        chk("R9 abort stays low", inj_abort, 0);
        step(); settle();
        chk("R9 value stored", ra(), 32'h1010_1010);
    endtask

    task automatic t_r0();
        step(); inj_trig = 1; inj_idx = 0; inj_val = 32'hFFFF_FFFF; rd(4'd0, 4'd1); settle();
        chk("R10 no done on reg0", inj_done, 0);
        step(); quiet(); settle();
        chk("R10 err set", inj_err, 1);
        chk("R10 busy low", inj_busy, 0);
        chk("R10 reg0 stays zero", ra(), 0);
        step(); pw_en = 1; pw_idx = 0; pw_data = 32'h1234; settle();
        step(); quiet(); settle();
        chk("R10 processor write to reg0 ignored", ra(), 0);
        step(); inj_trig = 1; inj_idx = 1; inj_val = 32'h0101; settle();
        step(); quiet(); settle();
        chk("R10 err cleared", inj_err, 0);
        chk("R10 reg1 injected", rb(), 32'h0101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_write();
        t_free_inject();
        t_collision();
        t_busy_ignore();
        t_timeout();
        t_no_timeout();
        t_r0();
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule